// File: doc/BRIEF.md
# Register-Driven Serial Flash Transfer Engine

This block moves one to four bytes per command between a host register bus and a serial flash or RAM port. The port can run in one of two forms. One form is a single-lane, full-duplex shift with one data line out and one data line in. The other is a four-lane half-duplex shift that moves a nibble on each clock pulse. The host starts a transfer by writing the word to send. The register address of that write selects both the lane mode and the byte count, so no separate length or mode register is needed. When the transfer has finished, the received bytes can be read from a response register, packed against its least significant end.

A control register handles the rest of the port. It selects one of the chip-select lines and asserts or releases it. It also drives a request line that asks for ownership of the shared flash pins. A chip select stays asserted while any number of commands run, so a single device transaction can be built from an opcode write, several data writes and a run of reads. A busy bit in the control register's readback tells the host when the current command has shifted its last bit. While that bit is set, further command writes are dropped.

Top module: `qspi_xfer_engine`

## Requirements
- R1: A write to an address from 0x10 to 0x1F starts a transfer. Address bits [3:2] select the mode: 00 is single-lane full duplex, 01 is a four-lane read, 10 is a four-lane data write and 11 is a four-lane command write. Address bits [1:0] hold the byte count n minus one.
- R2: A single-lane transfer gives 8n clock pulses. It sends the top 8n bits of the written word, most significant bit first, on io_out[0] with io_oe = 0001, and it samples io_in[1] on each rising clock edge.
- R3: A four-lane write, in either data or command mode, gives 2n clock pulses. It drives io_oe = 1111 and sends the top 8n bits of the written word on io_out[3:0], most significant nibble first.
- R4: A four-lane read gives 2n clock pulses with io_oe = 0000 for its whole duration, and it samples io_in[3:0] on each rising edge.
- R5: Register address 3 returns the received bits of the last single-lane transfer or four-lane read. The bits are right-aligned, the first bit received is the most significant, and the bytes above them read as zero. Four-lane writes leave this register unchanged.
- R6: spi_sck idles low and runs at half the system clock rate. Outgoing data changes only while the clock falls, and incoming data is taken as the clock rises.
- R7: Bit 0 of the control readback (address 0) is the busy flag. It is set by the edge that accepts a command and is cleared 16n cycles after that edge for a single-lane transfer, or 4n cycles after it for a four-lane transfer.
- R8: A command write that arrives while busy is set is ignored. The running transfer ends with its own pulse count, data and timing.
- R9: A write to address 0 sets the control state. Bit 1 drives spi_cs_n[sel] low, bits [5:4] give sel, and bit 2 drives own_req. All other chip selects stay high. The readback of address 0 shows these fields at the same bit positions.
- R10: An asserted chip select stays low across any number of commands until a control write clears bit 1.
- R11: qpi_cmd_flag is high while a four-lane command write is in progress and low during every other transfer.
- R12: After reset, all chip selects are high, spi_sck is low, io_oe is 0000, own_req is low and both readable registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write address (control register or command code) |
| wr_data | input | DATA_W | Host write word |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | DATA_W | Registered read data, one cycle after rd_addr |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | NCS | Active-low chip selects |
| io_out | output | 4 | Data lane output values |
| io_oe | output | 4 | Data lane output enables |
| io_in | input | 4 | Data lane input values |
| own_req | output | 1 | Request for ownership of the flash pins |
| qpi_cmd_flag | output | 1 | Marks a four-lane command-phase transfer |

## Verification
The bench runs every mode with every byte count. It checks the pulse count, the bits sent, the right-aligned response and the exact cycle on which busy clears. A decoder that swapped the mode bits or misread the count would give the wrong number of pulses. A response packed against the top of the word would leave the one-, two- and three-byte results shifted out of place. A command injected in the middle of a four-byte single-lane transfer checks that a busy engine does not reload its shifter: a design that failed here would send a truncated or mixed bit stream. The bench also checks that four-lane writes leave the response register alone. It checks that the four-lane read releases every lane, and that a chip select stays low from one command to the next rather than dropping between words.

// File: rtl/qspi_eng_pkg.sv
package qspi_eng_pkg;
  typedef enum logic [1:0] {
    XM_SPI  = 2'd0,
    XM_QRD  = 2'd1,
    XM_QWR  = 2'd2,
    XM_QCMD = 2'd3
  } xfer_mode_e;

  typedef struct packed {
    logic       go;
    xfer_mode_e mode;
    logic [1:0] nm1;
  } xfer_req_t;
endpackage

// File: rtl/qspi_cmd_decode.sv
module qspi_cmd_decode
  import qspi_eng_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output xfer_req_t         req,
  output logic              ctrl_we
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;
  localparam int                CMD_PAGE  = 1;

  always_comb begin
    req.go   = wr_en && (int'(wr_addr >> 4) == CMD_PAGE);
    req.mode = xfer_mode_e'(wr_addr[3:2]);
    req.nm1  = wr_addr[1:0];
    ctrl_we  = wr_en && (wr_addr == CTRL_ADDR);
  end
endmodule

// File: rtl/qspi_cs_ctrl.sv
module qspi_cs_ctrl #(
  parameter int NCS  = 4,
  parameter int CS_W = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ctrl_we,
  input  logic            set_on,
  input  logic            set_own,
  input  logic [CS_W-1:0] set_sel,
  output logic            cs_on,
  output logic            own_req,
  output logic [CS_W-1:0] cs_sel,
  output logic [NCS-1:0]  spi_cs_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_on   <= 1'b0;
      own_req <= 1'b0;
      cs_sel  <= '0;
    end else if (ctrl_we) begin
      cs_on   <= set_on;
      own_req <= set_own;
      cs_sel  <= set_sel;
    end
  end

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst) spi_cs_n[g] <= 1'b1;
      else if (ctrl_we) spi_cs_n[g] <= !(set_on && (int'(set_sel) == g));
    end
  end

  // R9
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~spi_cs_n));
  // R10
  cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_we |=> $stable(spi_cs_n));
endmodule

// File: rtl/qspi_shifter.sv
module qspi_shifter
  import qspi_eng_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  xfer_req_t         req,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [3:0]        io_in,
  output logic              spi_sck,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  output logic              busy,
  output logic              cmd_flag,
  output logic [DATA_W-1:0] resp
);
  xfer_mode_e        mode_q;
  logic [CNT_W-1:0]  pulses_left;
  logic [CNT_W-1:0]  nbytes;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic              start;
  logic              quad_q;
  logic              cap_q;

  assign start  = req.go && !busy;
  assign nbytes = CNT_W'({1'b0, req.nm1}) + CNT_W'(1);
  assign quad_q = (mode_q != XM_SPI);
  assign cap_q  = (mode_q == XM_SPI) || (mode_q == XM_QRD);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      spi_sck     <= 1'b0;
      mode_q      <= XM_SPI;
      pulses_left <= '0;
      tx_sh       <= '0;
      rx_sh       <= '0;
      io_oe       <= 4'b0000;
    end else if (start) begin
      busy        <= 1'b1;
      spi_sck     <= 1'b0;
      mode_q      <= req.mode;
      tx_sh       <= tx_word;
      pulses_left <= (req.mode == XM_SPI) ? (nbytes << 3) : (nbytes << 1);
      unique case (req.mode)
        XM_SPI:  io_oe <= 4'b0001;
        XM_QRD:  io_oe <= 4'b0000;
        default: io_oe <= 4'b1111;
      endcase
      if (req.mode == XM_SPI || req.mode == XM_QRD) rx_sh <= '0;
    end else if (busy) begin
      if (!spi_sck) begin
        spi_sck <= 1'b1;
        if (cap_q) begin
          if (quad_q) rx_sh <= {rx_sh[DATA_W-5:0], io_in};
          else        rx_sh <= {rx_sh[DATA_W-2:0], io_in[1]};
        end
      end else begin
        spi_sck     <= 1'b0;
        tx_sh       <= quad_q ? (tx_sh << 4) : (tx_sh << 1);
        pulses_left <= pulses_left - CNT_W'(1);
        if (pulses_left == CNT_W'(1)) busy <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (mode_q)
      XM_SPI:  io_out = {3'b000, tx_sh[DATA_W-1]};
      XM_QRD:  io_out = 4'b0000;
      default: io_out = tx_sh[DATA_W-1 -: 4];
    endcase
  end

  assign cmd_flag = busy && (mode_q == XM_QCMD);
  assign resp     = rx_sh;

  // R6
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !spi_sck);
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !spi_sck && !start) |=> $stable(io_out));
  // R4
  qrd_release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_q == XM_QRD) |-> (io_oe == 4'b0000));
  // R3
  qwr_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && (mode_q == XM_QWR || mode_q == XM_QCMD)) |-> (io_oe == 4'b1111));
  // R8
  ignore_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && req.go) |=> $stable(mode_q));
  // R11
  cmd_flag_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_flag |-> busy);
endmodule

// File: rtl/qspi_xfer_engine.sv
module qspi_xfer_engine
  import qspi_eng_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int NCS    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              spi_sck,
  output logic [NCS-1:0]    spi_cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in,
  output logic              own_req,
  output logic              qpi_cmd_flag
);
  localparam int                CS_W      = (NCS > 1) ? $clog2(NCS) : 1;
  localparam int                SEL_LSB   = 4;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] RESP_ADDR = ADDR_W'(3);

  xfer_req_t         req;
  logic              ctrl_we;
  logic              cs_on;
  logic [CS_W-1:0]   cs_sel;
  logic              busy;
  logic [DATA_W-1:0] resp;
  logic [DATA_W-1:0] ctrl_view;

  qspi_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .req     (req),
    .ctrl_we (ctrl_we)
  );

  qspi_cs_ctrl #(.NCS(NCS), .CS_W(CS_W)) u_cs (
    .clk      (clk),
    .rst      (rst),
    .ctrl_we  (ctrl_we),
    .set_on   (wr_data[1]),
    .set_own  (wr_data[2]),
    .set_sel  (wr_data[SEL_LSB +: CS_W]),
    .cs_on    (cs_on),
    .own_req  (own_req),
    .cs_sel   (cs_sel),
    .spi_cs_n (spi_cs_n)
  );

  qspi_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .tx_word  (wr_data),
    .io_in    (io_in),
    .spi_sck  (spi_sck),
    .io_out   (io_out),
    .io_oe    (io_oe),
    .busy     (busy),
    .cmd_flag (qpi_cmd_flag),
    .resp     (resp)
  );

  always_comb begin
    ctrl_view                     = '0;
    ctrl_view[0]                  = busy;
    ctrl_view[1]                  = cs_on;
    ctrl_view[2]                  = own_req;
    ctrl_view[SEL_LSB +: CS_W]    = cs_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_addr == CTRL_ADDR) rd_data <= ctrl_view;
    else if (rd_addr == RESP_ADDR) rd_data <= resp;
    else rd_data <= '0;
  end

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (req.go && !busy) |=> busy);
endmodule

// File: tb/qspi_xfer_engine_test.sv
module qspi_xfer_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        spi_sck;
  logic [3:0]  spi_cs_n;
  logic [3:0]  io_out;
  logic [3:0]  io_oe;
  logic [3:0]  io_in = '0;
  logic        own_req;
  logic        qpi_cmd_flag;

  int          n_chk = 0;
  int          n_bad = 0;
  int          cnt = 0;
  logic [63:0] cap = '0;
  logic        sl_quad = 1'b0;
  int          nbits = 8;
  logic [31:0] sw = '0;
  logic [31:0] last_resp = '0;
  int          cycles = 0;

  always #10 clk = ~clk;

  qspi_xfer_engine uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .own_req(own_req),
    .qpi_cmd_flag(qpi_cmd_flag)
  );

  always @(posedge spi_sck) begin
    cnt = cnt + 1;
    if (sl_quad) cap = (cap << 4) | 64'(io_out);
    else         cap = (cap << 1) | 64'(io_out[0]);
  end

  always @(negedge clk) begin
    if (sl_quad) io_in <= (cnt < nbits / 4) ? 4'((sw >> (nbits - 4 - 4 * cnt)) & 32'hf) : 4'h0;
    else         io_in <= (cnt < nbits) ? {2'b00, sw[nbits - 1 - cnt], 1'b0} : 4'h0;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ctrl_write(input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd0; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // mode: 0 single-lane, 1 quad read, 2 quad write, 3 quad command write
  task automatic xfer(input int mode, input int n, input logic [31:0] txw,
                      input logic [31:0] slave, input logic inject);
    int k;
    int t_exp;
    int p_exp;
    logic [31:0] mask;
    logic [31:0] r_exp;
    logic [63:0] c_exp;
    @(negedge clk);
    cnt = 0; cap = '0; sl_quad = (mode != 0); nbits = 8 * n; sw = slave;
    rd_addr = 5'd0;
    wr_en = 1'b1; wr_addr = 5'(16 + 4 * mode + n - 1); wr_data = txw;
    @(negedge clk);
    wr_en = 1'b0;
    t_exp = (mode == 0) ? 16 * n : 4 * n;
    p_exp = (mode == 0) ? 8 * n : 2 * n;
    k = 0;
    do begin
      @(negedge clk);
      k = k + 1;
      if (k == 2) begin
        // R2 R3 R4 lane direction during transfer
        chk(io_oe == ((mode == 0) ? 4'b0001 : (mode == 1) ? 4'b0000 : 4'b1111),
            "R2/R3/R4 io_oe", 64'(io_oe), 64'((mode == 0) ? 1 : (mode == 1) ? 0 : 15));
        // R11
        chk(qpi_cmd_flag == (mode == 3), "R11 cmd flag", 64'(qpi_cmd_flag), 64'(mode == 3));
      end
      if (inject && k == 3) begin
        wr_en = 1'b1; wr_addr = 5'h1C; wr_data = 32'hFFFF_FFFF;
      end
      if (inject && k == 4) wr_en = 1'b0;
    end while (rd_data[0] && k < 2000);
    // R7
    chk(k == t_exp + 1, "R7 busy duration", 64'(k), 64'(t_exp + 1));
    // R1 R8 pulse count
    chk(cnt == p_exp, inject ? "R8 pulses after ignored command" : "R1 pulse count",
        64'(cnt), 64'(p_exp));
    mask  = (n == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * n)) - 32'h1);
    if (mode != 1) begin
      c_exp = 64'(txw >> (32 - 8 * n));
      // R2 R3
      chk(cap == c_exp, (mode == 0) ? "R2 sent bits" : "R3 sent nibbles", cap, c_exp);
    end
    r_exp = (mode <= 1) ? (slave & mask) : last_resp;
    @(negedge clk);
    rd_addr = 5'd3;
    @(negedge clk);
    // R5
    chk(rd_data == r_exp, "R5 response", 64'(rd_data), 64'(r_exp));
    last_resp = r_exp;
    rd_addr = 5'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12
    chk(spi_cs_n == 4'hF && spi_sck == 1'b0 && io_oe == 4'h0 && own_req == 1'b0,
        "R12 reset outputs", {spi_cs_n, spi_sck, io_oe, own_req}, {4'hF, 1'b0, 4'h0, 1'b0});
    rd_addr = 5'd0; @(negedge clk);
    chk(rd_data == 32'h0, "R12 control readback", 64'(rd_data), 64'h0);
    rd_addr = 5'd3; @(negedge clk);
    chk(rd_data == 32'h0, "R12 response readback", 64'(rd_data), 64'h0);

    for (int s = 0; s < 4; s++) begin
      ctrl_write(32'h6 | (32'(s) << 4));
      // R9
      chk(spi_cs_n == ~(4'b1 << s) && own_req, "R9 select", {spi_cs_n, own_req},
          {~(4'b1 << s), 1'b1});
      rd_addr = 5'd0; @(negedge clk);
      chk(rd_data == (32'h6 | (32'(s) << 4)), "R9 readback", 64'(rd_data),
          64'(32'h6 | (32'(s) << 4)));
    end
    ctrl_write(32'h4);
    chk(spi_cs_n == 4'hF && own_req, "R9 release keeps request", {spi_cs_n, own_req}, {4'hF, 1'b1});
    ctrl_write(32'h0);
    chk(own_req == 1'b0, "R9 request dropped", 64'(own_req), 64'h0);

    ctrl_write(32'h26);
    for (int m = 0; m < 4; m++) begin
      for (int n = 1; n <= 4; n++) begin
        xfer(m, n, 32'hA5C3_0000 ^ (32'(m) << 8) ^ 32'(n * 32'h1F2E_3D11),
             32'h9E37_79B9 ^ (32'(m * 4 + n) * 32'h0101_0103), 1'b0);
        // R10
        chk(spi_cs_n == 4'b1011, "R10 select held across commands", 64'(spi_cs_n), 64'hB);
      end
    end
    xfer(0, 4, 32'h1357_9BDF, 32'hC0FF_EE42, 1'b1);
    xfer(2, 3, 32'hDEAD_BEEF, 32'h0, 1'b0);
    xfer(1, 1, 32'h0, 32'h0000_003C, 1'b0);
    ctrl_write(32'h0);
    chk(spi_cs_n == 4'hF, "R10 select cleared", 64'(spi_cs_n), 64'hF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule